// File: doc/BRIEF.md
# Periodic Compare Pulse Generator

The block runs a free-running up-counter and watches it with two compare units that share one request flag. When the counter reaches the value in the "set" compare, the flag goes high. When it reaches the value in the "clear" compare, the flag drops again, if automatic clearing is turned on. Each compare unit moves its own threshold forward by a programmable step every time it hits. With equal steps, the output is a periodic pulse. Its width in counter ticks is the distance between the two thresholds, so a consumer on a slower clock still sees it.

Software programs the block through a small synchronous write port and observes it through a combinational read port. Software can also drop the flag at any time by writing one to the flag register. An enable bit gates the raw flag onto the request output. The flag register always reports the ungated flag.

Register map (3-bit address): 0 control, 1 flag, 2 set threshold, 3 clear threshold, 4 set step, 5 clear step, 6 counter (read-only). Control bits: bit0 count run, bit1 auto-clear, bit2 request enable. Flag register: bit0 is the flag. Unused read addresses return zero.

Top module: `tick_pulse_gen`

## Requirements
- R1: After reset, every register at addresses 0 to 6 reads zero and req_o is low.
- R2: The counter (address 6) increases by one on each clock while control bit0 is set, holds its value while bit0 is clear, and ignores writes.
- R3: When the running counter equals the set threshold (address 2), the flag (address 1, bit0) reads one from the next clock on.
- R4: With control bit1 set, when the running counter equals the clear threshold (address 3), the flag reads zero from the next clock on. With thresholds S and C, the flag stays high for C-S clocks.
- R5: On a match, each threshold adds its own step (address 4 for set, 5 for clear), modulo 2^32. Example: set 1000, clear 1002, both steps 5000 gives thresholds 6000 and 6002 after the first pulse.
- R6: With control bit1 clear, the flag stays set through a clear-threshold match until software clears it.
- R7: Writing a value with bit0 = 1 to address 1 clears the flag. Writing bit0 = 0 leaves it unchanged.
- R8: A set match wins over a clear match and over a software clear in the same cycle, and the flag ends up set.
- R9: req_o equals the flag ANDed with control bit2. Address 1 shows the raw flag whatever bit2 is.
- R10: Thresholds match only while the counter runs. A written threshold is used from the next clock. A write on a match cycle replaces that unit's step advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Read data for rd_addr (combinational) |
| req_o | output | 1 | Gated request output |

## Verification
Three updates can land on the flag in one cycle: a set match, a clear match and a software clear. Two updates can land on a threshold in one cycle: a software write and the automatic step advance. The bench provokes each clash on purpose. It polls the counter until it reads the threshold, then issues the competing write in exactly that cycle, or it programs equal set and clear thresholds. Random traffic then mixes all of these freely. A per-cycle reference model derived from R3 to R10 judges the flag, the request and every readable register at each falling edge.

// File: rtl/tick_pkg.sv
// Shared register addresses and control-bit positions for the pulse generator.
package tick_pkg;
    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_FLAG  = 3'd1,
        REG_SET   = 3'd2,
        REG_CLR   = 3'd3,
        REG_SSTEP = 3'd4,
        REG_CSTEP = 3'd5,
        REG_COUNT = 3'd6
    } reg_addr_e;

    localparam int CTRL_W    = 3;
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_AUTO = 1;
    localparam int CTRL_IE   = 2;
    localparam int NUM_CMP   = 2;   // index 0 = set unit, 1 = clear unit
endpackage

// File: rtl/tick_counter.sv
// Free-running up-counter.
// Assumes: run is a registered enable. The counter wraps modulo 2^W.
module tick_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Count one tick per clock while running, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tick_compare.sv
// One self-advancing compare unit: a threshold and a step register.
// A hit is flagged when the running counter equals the threshold. On a hit
// the threshold adds the step. A software write to the threshold overrides
// that advance. Assumes wr_cmp and wr_step are never high together.
module tick_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic         wr_cmp,
    input  logic         wr_step,
    input  logic [W-1:0] wr_data,
    output logic         hit_o,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] step_o
);
    logic [W-1:0] cmp_q, step_q, cmp_d;

    // Exact-equality match, only while counting.
    always_comb hit_o = run && (cnt == cmp_q);

    // Next threshold: software write first, then the step advance.
    always_comb begin
        cmp_d = cmp_q;
        if (wr_cmp)     cmp_d = wr_data;
        else if (hit_o) cmp_d = cmp_q + step_q;
    end

    // Hold the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    // Hold the step, loaded only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       step_q <= '0;
        else if (wr_step) step_q <= wr_data;
    end

    assign cmp_o  = cmp_q;
    assign step_o = step_q;
endmodule

// File: rtl/tick_flag.sv
// Request flag with priority: set hit > (auto clear hit | software clear).
// Assumes all inputs are single-cycle qualified strobes.
module tick_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hit,
    input  logic clr_hit,
    input  logic auto_en,
    input  logic sw_clr,
    output logic flag_o
);
    logic flag_q;

    // Update the flag with set taking precedence over both clear sources.
    always_ff @(posedge clk) begin
        if (!rst_n)                            flag_q <= 1'b0;
        else if (set_hit)                      flag_q <= 1'b1;
        else if ((clr_hit && auto_en) || sw_clr) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tick_regif.sv
// Register write decode, control register and read multiplexer.
// Assumes a single write per clock. Reads are combinational.
module tick_regif
    import tick_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [W-1:0]        wr_data,
    input  logic [2:0]          rd_addr,
    input  logic [W-1:0]        cnt,
    input  logic [W-1:0]        cmp_val  [NUM_CMP],
    input  logic [W-1:0]        step_val [NUM_CMP],
    input  logic                flag,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [NUM_CMP-1:0]  we_cmp,
    output logic [NUM_CMP-1:0]  we_step,
    output logic                sw_clr,
    output logic [W-1:0]        rd_data
);
    logic [CTRL_W-1:0] ctrl_q;

    // Hold the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ctrl_q <= '0;
        else if (wr_en && wr_addr == REG_CTRL)      ctrl_q <= wr_data[CTRL_W-1:0];
    end

    // Per-unit write strobes, one pair per compare unit.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_we
        assign we_cmp[g]  = wr_en && (wr_addr == 3'(REG_SET + g));
        assign we_step[g] = wr_en && (wr_addr == 3'(REG_SSTEP + g));
    end

    // Write-one-to-clear strobe for the flag.
    assign sw_clr = wr_en && (wr_addr == REG_FLAG) && wr_data[0];

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL:  rd_data = W'(ctrl_q);
            REG_FLAG:  rd_data = W'(flag);
            REG_SET:   rd_data = cmp_val[0];
            REG_CLR:   rd_data = cmp_val[1];
            REG_SSTEP: rd_data = step_val[0];
            REG_CSTEP: rd_data = step_val[1];
            REG_COUNT: rd_data = cnt;
            default:   rd_data = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tick_pulse_gen.sv
// Top: counter, set/clear compare units, request flag and register port.
// Produces a periodic pulse whose width is the clear/set threshold distance.
// Assumes a synchronous active-low reset on the single clock.
module tick_pulse_gen
    import tick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             req_o
);
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cmp_val  [NUM_CMP];
    logic [CNT_W-1:0]   step_val [NUM_CMP];
    logic [NUM_CMP-1:0] hit, we_cmp, we_step;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               sw_clr, flag_q;

    tick_regif #(.W(CNT_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt_q),
        .cmp_val(cmp_val), .step_val(step_val), .flag(flag_q),
        .ctrl_o(ctrl_q), .we_cmp(we_cmp), .we_step(we_step),
        .sw_clr(sw_clr), .rd_data(rd_data)
    );

    tick_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTRL_RUN]), .cnt_o(cnt_q)
    );

    // Two identical compare units: 0 sets, 1 clears.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        tick_compare #(.W(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTRL_RUN]), .cnt(cnt_q),
            .wr_cmp(we_cmp[g]), .wr_step(we_step[g]), .wr_data(wr_data),
            .hit_o(hit[g]), .cmp_o(cmp_val[g]), .step_o(step_val[g])
        );
    end

    tick_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_hit(hit[0]), .clr_hit(hit[1]),
        .auto_en(ctrl_q[CTRL_AUTO]), .sw_clr(sw_clr), .flag_o(flag_q)
    );

    assign req_o = flag_q & ctrl_q[CTRL_IE];
endmodule

// File: rtl/tick_pulse_chk.sv
// Checker for tick_pulse_gen, attached by bind below.
module tick_pulse_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   ctrl,
    input logic [W-1:0] cnt,
    input logic [W-1:0] set_cmp,
    input logic [W-1:0] clr_cmp,
    input logic [W-1:0] set_step,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic         flag,
    input logic         req
);
    // R2
    cnt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] |=> cnt == $past(cnt) + W'(1));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |=> $stable(cnt));
    // R3
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && cnt == set_cmp) |=> flag);
    // R4
    auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && ctrl[1] && cnt == clr_cmp && cnt != set_cmp) |=> !flag);
    // R5
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && cnt == set_cmp && !(wr_en && wr_addr == 3'd2))
        |=> set_cmp == $past(set_cmp) + $past(set_step));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctrl[1] && !(wr_en && wr_addr == 3'd1 && wr_data[0])) |=> flag);
    // R9
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (flag && ctrl[2]));
endmodule

bind tick_pulse_gen tick_pulse_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .cnt(cnt_q),
    .set_cmp(cmp_val[0]), .clr_cmp(cmp_val[1]), .set_step(step_val[0]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag(flag_q), .req(req_o)
);

// File: tb/test_tick_pulse_gen.sv
`timescale 1ns/1ps
module test_tick_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        req_o;

    int n_chk = 0;
    int n_err = 0;

    tick_pulse_gen i_tick_pulse_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .req_o(req_o)
    );

    always #5 clk = ~clk;

    // Reference model built from R2..R10.
    logic [31:0] m_cnt, m_set, m_clr, m_ss, m_cs;
    logic [2:0]  m_ctrl;
    logic        m_flag;

    always @(posedge clk) begin
        logic sh, ch, swc;
        if (!rst_n) begin
            m_cnt <= 0; m_set <= 0; m_clr <= 0; m_ss <= 0; m_cs <= 0;
            m_ctrl <= 0; m_flag <= 0;
        end else begin
            sh  = m_ctrl[0] && m_cnt == m_set;
            ch  = m_ctrl[0] && m_cnt == m_clr;
            swc = wr_en && wr_addr == 3'd1 && wr_data[0];
            if (m_ctrl[0]) m_cnt <= m_cnt + 1;
            if (sh) m_flag <= 1'b1;
            else if ((ch && m_ctrl[1]) || swc) m_flag <= 1'b0;
            if (wr_en && wr_addr == 3'd2) m_set <= wr_data;
            else if (sh) m_set <= m_set + m_ss;
            if (wr_en && wr_addr == 3'd3) m_clr <= wr_data;
            else if (ch) m_clr <= m_clr + m_cs;
            if (wr_en && wr_addr == 3'd4) m_ss <= wr_data;
            if (wr_en && wr_addr == 3'd5) m_cs <= wr_data;
            if (wr_en && wr_addr == 3'd0) m_ctrl <= wr_data[2:0];
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {29'd0, m_ctrl};
            3'd1: return {31'd0, m_flag};
            3'd2: return m_set;
            3'd3: return m_clr;
            3'd4: return m_ss;
            3'd5: return m_cs;
            3'd6: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock with given write and read address, then compare against the model.
    task automatic cyc(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                       input logic [2:0] ra, input string tag);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(tag, rd_data, m_read(ra));
        chk(tag, {31'd0, req_o}, {31'd0, m_flag & m_ctrl[2]});
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 3'd6, "R2 R10");
    endtask

    task automatic wait_count(input logic [31:0] v);
        for (int i = 0; i < 20000; i++) begin
            rd_addr = 3'd6;
            #1;
            if (rd_data == v) return;
            cyc(1'b0, 3'd0, 0, 3'd6, "R2");
        end
        chk("R2 wait", rd_data, v);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] s;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 7; a++) rd_chk(3'(a), 0, "R1");
        chk("R1 req", {31'd0, req_o}, 0);

        // R5 example: 1000/1002, steps 5000, auto + enable
        wr(3'd2, 1000); wr(3'd3, 1002); wr(3'd4, 5000); wr(3'd5, 5000);
        wr(3'd6, 77);
        rd_chk(3'd6, 0, "R2 count ignores write and holds while stopped");
        wr(3'd0, 7);
        wait_count(1000);
        chk("R3 before", {31'd0, req_o}, 0);
        cyc(1'b0, 0, 0, 3'd1, "R3");
        chk("R3 flag set", rd_data, 1);
        chk("R9 req", {31'd0, req_o}, 1);
        cyc(1'b0, 0, 0, 3'd1, "R4");
        chk("R4 width", rd_data, 1);
        cyc(1'b0, 0, 0, 3'd1, "R4");
        chk("R4 auto clear", rd_data, 0);
        rd_chk(3'd2, 6000, "R5 set advance");
        rd_chk(3'd3, 6002, "R5 clear advance");
        wait_count(6001);
        chk("R5 second pulse", {31'd0, req_o}, 1);

        // R6/R7: auto off, flag holds; W1C
        wr(3'd0, 5);
        wait_count(11003);
        rd_chk(3'd1, 1, "R6 flag holds");
        cyc(1'b1, 3'd1, 0, 3'd1, "R7");
        chk("R7 write zero", rd_data, 1);
        cyc(1'b1, 3'd1, 1, 3'd1, "R7");
        chk("R7 write one", rd_data, 0);

        // R9: request gated off, raw flag visible
        wr(3'd0, 1);
        wait_count(16001);
        rd_chk(3'd1, 1, "R9 raw flag");
        chk("R9 gated", {31'd0, req_o}, 0);

        // R8: set and clear equal; then W1C on a set-match cycle
        wr(3'd0, 0);
        cyc(1'b1, 3'd1, 1, 3'd6, "R7");
        rd_addr = 3'd6; #1; s = rd_data;
        wr(3'd2, s + 20); wr(3'd3, s + 20); wr(3'd4, 40); wr(3'd5, 40);
        wr(3'd0, 7);
        wait_count(s + 21);
        rd_chk(3'd1, 1, "R8 set beats clear");
        cyc(1'b1, 3'd1, 1, 3'd1, "R7");
        wait_count(s + 60);
        cyc(1'b1, 3'd1, 1, 3'd1, "R8");
        chk("R8 set beats sw clear", rd_data, 1);

        // R10: write on match overrides advance; stopped counter no match
        rd_addr = 3'd6; #1; s = rd_data;
        cyc(1'b1, 3'd1, 1, 3'd6, "R7");
        wr(3'd2, s + 10);
        wait_count(s + 10);
        cyc(1'b1, 3'd2, s + 200, 3'd1, "R10");
        chk("R10 match still sets", rd_data, 1);
        rd_chk(3'd2, s + 200, "R10 write beats advance");
        cyc(1'b1, 3'd1, 1, 3'd1, "R7");
        wr(3'd0, 6);
        rd_addr = 3'd6; #1; s = rd_data;
        wr(3'd2, s);
        repeat (4) cyc(1'b0, 0, 0, 3'd1, "R10");
        rd_chk(3'd1, 0, "R10 no match while stopped");
        rd_chk(3'd6, s, "R2 hold");

        // Random phase against the model
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            int unsigned r = $urandom % 16;
            logic [2:0] ra = 3'($urandom % 8);
            if (r < 5) begin
                logic [2:0] wa = 3'($urandom % 7);
                logic [31:0] wd;
                case (wa)
                    3'd0: wd = ($urandom % 4 == 0) ? $urandom : 32'(($urandom % 8) | 1);
                    3'd1: wd = $urandom;
                    3'd2, 3'd3: wd = m_cnt + ($urandom % 40);
                    default: wd = ($urandom % 40) + 1;
                endcase
                cyc(1'b1, wa, wd, ra, "R3 R4 R5 R7 R8 R10 random");
            end else begin
                cyc(1'b0, 0, 0, ra, "R2 R3 R4 R6 R9 random");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule